// File: doc/BRIEF.md
# Multi-Channel Byte-Copy DMA Controller

This block moves bytes between a memory-mapped source and destination on behalf of several independent channels. Software configures each channel through a 32-bit register window: an addressing mode for each side, a source address, a destination address and a byte count. Writing the shared command word then launches or cancels any group of channels at once. Every channel that is running competes for a single byte-wide memory port. A beat reads one byte and, in the next cycle, writes that byte back out.

The addresses and the byte count are working registers. They advance with every beat, so reading them while a channel runs shows where the copy stands and how many bytes are still to go. A channel reports the end of its copy, or the fact that it was cancelled, with one-cycle event pulses. An interrupt unit outside this block collects those pulses.

Top module: `mdma_ctrl`

## Requirements
- R1: After reset no channel runs, `mem_req` is low, no event pulse is raised and every channel register reads 0.
- R2: Channel n's registers sit at 0x100 + 0x40*n: source mode at +0x20, destination mode at +0x24, source address at +0x28, destination address at +0x2C and byte count at +0x30. A mode register stores and returns only bits [5:4]. Writes to a running channel's registers are ignored.
- R3: A write to offset 0x000 with bit 31 clear starts each channel whose bit is set in bits [NCH-1:0]. A start aimed at a running channel is ignored. A start with a count of 0 pulses that channel's done event in the next cycle and makes no memory access.
- R4: A beat drives a read (`mem_req`=1, `mem_we`=0) at the source address. In the following cycle it drives a write at the destination address whose data is `mem_rdata`, which the memory returns one cycle after the read. The first read appears in the cycle after the start command's clock edge.
- R5: The mode code in bits [5:4] steps the address after each beat: 0 increments it, 1 decrements it, and 2 (or 3) keeps it fixed.
- R6: The byte count drops by one per beat and reads back the bytes still to move. It reads 0 at the end. The done event pulses for one cycle in the cycle after the final write, so a copy of N bytes signals 2N cycles after the start edge.
- R7: A command write with bit 31 set cancels the selected channels. Each one pulses both its abort and done events in the next cycle, whether it was running or idle. A byte already read still gets written, and no further memory access is made for that channel.
- R8: Running channels take beats in rotating order, so two running channels alternate beat by beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Byte being written |
| mem_rdata | input | 8 | Byte read, valid one cycle after a read request |
| evt_done | output | NCH | Per-channel completion pulse |
| evt_abort | output | NCH | Per-channel cancellation pulse |

## Verification
A channel whose running flag is stuck shows up in two ways. If it stays set, the memory port keeps issuing accesses after the count reaches 0. If it is lost, the done pulse never arrives. Both are visible within one beat, that is two cycles. A wrong address step or a wrong count decrement appears at once in the read-back registers and in the bytes written to the destination. An arbiter pointer that fails to rotate shows up within two beats, because two running channels stop alternating their write addresses. A beat whose read and write lose their pairing writes the wrong byte at the very next write cycle.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

    localparam int DW = 32;

    typedef enum logic [1:0] {
        AM_INC = 2'd0,
        AM_DEC = 2'd1,
        AM_FIX = 2'd2,
        AM_RSV = 2'd3
    } addr_mode_e;

    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_SMODE,
        FLD_DMODE,
        FLD_SADDR,
        FLD_DADDR,
        FLD_COUNT
    } field_e;

    typedef struct packed {
        addr_mode_e      src_mode;
        addr_mode_e      dst_mode;
        logic [DW-1:0]   src_addr;
        logic [DW-1:0]   dst_addr;
        logic [DW-1:0]   remain;
    } chan_cfg_t;

    localparam int          CMD_CANCEL_BIT = 31;
    localparam int          CH_WIN_SHIFT   = 6;    // 0x40 bytes per channel
    localparam int          CH_WIN_FIRST   = 4;    // 0x100 >> 6
    localparam int          MODE_LSB       = 4;

    function automatic logic [DW-1:0] next_addr(logic [DW-1:0] a, addr_mode_e m);
        case (m)
            AM_INC:  return a + DW'(1);
            AM_DEC:  return a - DW'(1);
            default: return a;
        endcase
    endfunction

    function automatic field_e decode_field(logic [5:0] ofs);
        case (ofs)
            6'h20:   return FLD_SMODE;
            6'h24:   return FLD_DMODE;
            6'h28:   return FLD_SADDR;
            6'h2C:   return FLD_DADDR;
            6'h30:   return FLD_COUNT;
            default: return FLD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mdma_chan.sv
module mdma_chan
    import mdma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  field_e          wr_field,
    input  logic [DW-1:0]   wr_data,
    input  logic            start,
    input  logic            cancel,
    input  logic            step,
    output chan_cfg_t       cfg,
    output logic            busy,
    output logic            ev_done,
    output logic            ev_abort
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            busy     <= 1'b0;
            ev_done  <= 1'b0;
            ev_abort <= 1'b0;
        end else begin
            ev_done  <= 1'b0;
            ev_abort <= 1'b0;

            // Working registers: a beat has priority over software writes.
            if (step) begin
                cfg.src_addr <= next_addr(cfg.src_addr, cfg.src_mode);
                cfg.dst_addr <= next_addr(cfg.dst_addr, cfg.dst_mode);
                cfg.remain   <= cfg.remain - DW'(1);
            end else if (wr_en && !busy) begin
                case (wr_field)
                    FLD_SMODE: cfg.src_mode <= addr_mode_e'(wr_data[MODE_LSB+1:MODE_LSB]);
                    FLD_DMODE: cfg.dst_mode <= addr_mode_e'(wr_data[MODE_LSB+1:MODE_LSB]);
                    FLD_SADDR: cfg.src_addr <= wr_data;
                    FLD_DADDR: cfg.dst_addr <= wr_data;
                    FLD_COUNT: cfg.remain   <= wr_data;
                    default:   ;
                endcase
            end

            // Run state and events.
            if (cancel) begin
                busy     <= 1'b0;
                ev_abort <= 1'b1;
                ev_done  <= 1'b1;
            end else if (step && busy && cfg.remain == DW'(1)) begin
                busy    <= 1'b0;
                ev_done <= 1'b1;
            end else if (start && !busy) begin
                if (cfg.remain == '0) ev_done <= 1'b1;
                else                  busy    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mdma_rr_arb.sv
module mdma_rr_arb #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic          any,
    output logic [IW-1:0] win
);

    logic [IW-1:0] last_q;

    always_comb begin
        any = 1'b0;
        win = '0;
        for (int k = 1; k <= N; k++) begin
            if (!any && req[(int'(last_q) + k) % N]) begin
                any = 1'b1;
                win = IW'((int'(last_q) + k) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                last_q <= IW'(N - 1);
        else if (take && any)   last_q <= win;
    end

endmodule

// File: rtl/mdma_beat_eng.sv
module mdma_beat_eng
    import mdma_pkg::*;
#(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    running,
    input  chan_cfg_t       cfg [N],
    output logic [N-1:0]    step,
    output logic            mem_req,
    output logic            mem_we,
    output logic [DW-1:0]   mem_addr,
    output logic [7:0]      mem_wdata,
    input  logic [7:0]      mem_rdata
);

    typedef enum logic {ENG_READ, ENG_WRITE} eng_state_e;

    eng_state_e     state_q;
    logic [IW-1:0]  sel_q;
    logic           any;
    logic [IW-1:0]  win;
    logic           take;

    assign take = (state_q == ENG_READ) && any;

    mdma_rr_arb #(.N(N)) u_arb (
        .clk  (clk),
        .rst  (rst),
        .req  (running),
        .take (take),
        .any  (any),
        .win  (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_READ;
            sel_q   <= '0;
        end else if (state_q == ENG_WRITE) begin
            state_q <= ENG_READ;
        end else if (take) begin
            state_q <= ENG_WRITE;
            sel_q   <= win;
        end
    end

    always_comb begin
        step      = '0;
        mem_wdata = mem_rdata;
        if (state_q == ENG_WRITE) begin
            mem_req     = 1'b1;
            mem_we      = 1'b1;
            mem_addr    = cfg[sel_q].dst_addr;
            step[sel_q] = 1'b1;
        end else begin
            mem_req  = any;
            mem_we   = 1'b0;
            mem_addr = cfg[win].src_addr;
        end
    end

endmodule

// File: rtl/mdma_ctrl.sv
module mdma_ctrl
    import mdma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata,
    output logic [NCH-1:0]   evt_done,
    output logic [NCH-1:0]   evt_abort
);

    localparam int WIW = AW - CH_WIN_SHIFT;

    logic [WIW-1:0]  win_no;
    logic [WIW-1:0]  ch_no;
    logic            ch_hit;
    logic            cmd_hit;
    field_e          field;
    logic [NCH-1:0]  ch_busy;
    logic [NCH-1:0]  ch_step;
    logic [NCH-1:0]  start_vec;
    logic [NCH-1:0]  cancel_vec;
    chan_cfg_t       cfg [NCH];

    assign win_no  = reg_addr[AW-1:CH_WIN_SHIFT];
    assign ch_no   = win_no - WIW'(CH_WIN_FIRST);
    assign ch_hit  = (int'(win_no) >= CH_WIN_FIRST) && (int'(ch_no) < NCH);
    assign cmd_hit = (reg_addr == '0);
    assign field   = decode_field(reg_addr[5:0]);

    assign start_vec  = (reg_wr && cmd_hit && !reg_wdata[CMD_CANCEL_BIT]) ? reg_wdata[NCH-1:0] : '0;
    assign cancel_vec = (reg_wr && cmd_hit &&  reg_wdata[CMD_CANCEL_BIT]) ? reg_wdata[NCH-1:0] : '0;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        mdma_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (reg_wr && ch_hit && (int'(ch_no) == g)),
            .wr_field (field),
            .wr_data  (reg_wdata),
            .start    (start_vec[g]),
            .cancel   (cancel_vec[g]),
            .step     (ch_step[g]),
            .cfg      (cfg[g]),
            .busy     (ch_busy[g]),
            .ev_done  (evt_done[g]),
            .ev_abort (evt_abort[g])
        );
    end

    mdma_beat_eng #(.N(NCH)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .running   (ch_busy),
        .cfg       (cfg),
        .step      (ch_step),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    always_comb begin
        reg_rdata = '0;
        if (ch_hit) begin
            for (int c = 0; c < NCH; c++) begin
                if (int'(ch_no) == c) begin
                    case (field)
                        FLD_SMODE: reg_rdata[MODE_LSB+1:MODE_LSB] = cfg[c].src_mode;
                        FLD_DMODE: reg_rdata[MODE_LSB+1:MODE_LSB] = cfg[c].dst_mode;
                        FLD_SADDR: reg_rdata = cfg[c].src_addr;
                        FLD_DADDR: reg_rdata = cfg[c].dst_addr;
                        FLD_COUNT: reg_rdata = cfg[c].remain;
                        default:   reg_rdata = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/mdma_ctrl_chk.sv
module mdma_ctrl_chk #(
    parameter int NCH = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            mem_req,
    input logic            mem_we,
    input logic [NCH-1:0]  evt_done,
    input logic [NCH-1:0]  evt_abort,
    input logic [NCH-1:0]  busy,
    input logic [NCH-1:0]  step
);

    // R4: a read is always followed by its write
    a_r4_read_then_write: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> (mem_req && mem_we));

    // R4: a write never follows a write
    a_r4_no_back_to_back_write: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R4: write only with a request
    a_r4_write_has_req: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

    // R7: cancellation always comes with done
    a_r7_abort_with_done: assert property (@(posedge clk) disable iff (rst)
        (evt_abort & ~evt_done) == '0);

    // R8: at most one channel stepped per cycle
    a_r8_single_step: assert property (@(posedge clk) disable iff (rst)
        $onehot0(step));

    for (genvar g = 0; g < NCH; g++) begin : g_c
        // R6: a channel stops only with a done pulse
        a_r6_stop_signals_done: assert property (@(posedge clk) disable iff (rst)
            $fell(busy[g]) |-> evt_done[g]);
        // R6: done pulses last one cycle
        a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
            evt_done[g] |=> !evt_done[g] || $past(evt_abort[g]) == 1'b0);
    end

endmodule

bind mdma_ctrl mdma_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .evt_done  (evt_done),
    .evt_abort (evt_abort),
    .busy      (ch_busy),
    .step      (ch_step)
);

// File: tb/mdma_ctrl_bench.sv
`timescale 1ns/1ps
module mdma_ctrl_bench;

    localparam int NCH = 4;
    localparam int AW  = 12;

    logic             clk = 1'b0;
    logic             rst;
    logic             reg_wr;
    logic [AW-1:0]    reg_addr;
    logic [31:0]      reg_wdata;
    logic [31:0]      reg_rdata;
    logic             mem_req, mem_we;
    logic [31:0]      mem_addr;
    logic [7:0]       mem_wdata;
    logic [7:0]       mem_rdata;
    logic [NCH-1:0]   evt_done, evt_abort;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [7:0]  mem [256];
    logic [7:0]  wlog [64];
    int          wcnt;

    always #2 clk = ~clk;

    mdma_ctrl #(.NCH(NCH), .AW(AW)) u_mdma_ctrl (
        .clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
        .evt_done, .evt_abort
    );

    function automatic logic [7:0] pat(int i);
        return 8'(i * 7 + 3);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i);
            wcnt <= 0;
        end else if (mem_req && mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            if (wcnt < 64) wlog[wcnt] <= mem_addr[7:0];
            wcnt <= wcnt + 1;
        end else if (mem_req) begin
            mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    function automatic logic [AW-1:0] ra(int ch, int ofs);
        return AW'(32'h100 + 32'h40 * ch + ofs);
    endfunction

    task automatic setup(int ch, int sm, int dm, int sa, int da, int n);
        wr(ra(ch, 'h20), 32'(sm << 4));
        wr(ra(ch, 'h24), 32'(dm << 4));
        wr(ra(ch, 'h28), 32'(sa));
        wr(ra(ch, 'h2C), 32'(da));
        wr(ra(ch, 'h30), 32'(n));
    endtask

    task automatic wait_done(int ch, int maxc, output int n);
        n = 0;
        while (!evt_done[ch] && n < maxc) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check(mem_req == 0, "R1 mem_req", mem_req, 0);
        check(evt_done == 0 && evt_abort == 0, "R1 events", {evt_done, evt_abort}, 0);
        rd(ra(1, 'h30), v);
        check(v == 0, "R1 count", v, 0);
        rd(ra(3, 'h28), v);
        check(v == 0, "R1 src addr", v, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        setup(2, 1, 2, 32'h12345678, 32'h0BADF00D, 32'h55);
        rd(ra(2, 'h20), v); check(v == 32'h10, "R2 smode", v, 32'h10);
        rd(ra(2, 'h24), v); check(v == 32'h20, "R2 dmode", v, 32'h20);
        rd(ra(2, 'h28), v); check(v == 32'h12345678, "R2 saddr", v, 32'h12345678);
        rd(ra(2, 'h2C), v); check(v == 32'h0BADF00D, "R2 daddr", v, 32'h0BADF00D);
        rd(ra(2, 'h30), v); check(v == 32'h55, "R2 count", v, 32'h55);
        wr(ra(2, 'h20), 32'hFFFF_FFFF);
        rd(ra(2, 'h20), v); check(v == 32'h30, "R2 mode bits only", v, 32'h30);
    endtask

    task automatic t_copy_inc();
        logic [31:0] v;
        int n;
        setup(0, 0, 0, 'h10, 'h40, 4);
        wr(12'h000, 32'h1);
        check(mem_req && !mem_we && mem_addr == 32'h10, "R4 first read", mem_addr, 32'h10);
        @(negedge clk);
        check(mem_we && mem_addr == 32'h40 && mem_wdata == pat('h10), "R4 paired write",
              mem_wdata, pat('h10));
        n = 1;
        while (!evt_done[0] && n < 50) begin
            @(negedge clk);
            n++;
            if (n == 4) begin
                rd(ra(0, 'h30), v);
                check(v == 2, "R6 live count", v, 2);
            end
        end
        check(n == 8, "R6 done timing", n, 8);
        rd(ra(0, 'h30), v); check(v == 0, "R6 count zero", v, 0);
        rd(ra(0, 'h28), v); check(v == 32'h14, "R5 inc src", v, 32'h14);
        for (int i = 0; i < 4; i++)
            check(mem['h40 + i] == pat('h10 + i), "R4 copied byte", mem['h40 + i], pat('h10 + i));
    endtask

    task automatic t_dec_fixed();
        logic [31:0] v;
        int n;
        setup(1, 1, 2, 'h80, 'h30, 3);
        wr(12'h000, 32'h2);
        wait_done(1, 50, n);
        check(evt_done[1], "R6 done seen", evt_done[1], 1);
        rd(ra(1, 'h28), v); check(v == 32'h7D, "R5 dec src", v, 32'h7D);
        rd(ra(1, 'h2C), v); check(v == 32'h30, "R5 fixed dst", v, 32'h30);
        check(mem['h30] == pat('h7E), "R5 last byte at fixed dst", mem['h30], pat('h7E));
        check(mem['h31] == pat('h31), "R5 fixed dst neighbour", mem['h31], pat('h31));
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        int n;
        setup(0, 0, 0, 'h20, 'h50, 6);
        wr(12'h000, 32'h1);
        wr(ra(0, 'h30), 32'd100);
        wr(12'h000, 32'h1);
        wait_done(0, 60, n);
        check(evt_done[0], "R3 done seen", evt_done[0], 1);
        rd(ra(0, 'h30), v); check(v == 0, "R2 write while busy ignored", v, 0);
        check(mem['h56] == pat('h56), "R3 no extra bytes", mem['h56], pat('h56));
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (mem_req) check(0, "R3 restart ignored", 1, 0);
        end
        check(mem['h55] == pat('h25), "R3 last byte", mem['h55], pat('h25));
    endtask

    task automatic t_zero();
        setup(2, 0, 0, 'h00, 'hF0, 0);
        wr(12'h000, 32'h4);
        check(evt_done[2] && !mem_req, "R3 zero-count done", {evt_done[2], mem_req}, 2'b10);
        @(negedge clk);
        check(!evt_done[2] && !mem_req, "R3 zero-count single pulse", {evt_done[2], mem_req}, 0);
    endtask

    task automatic t_rr();
        int base;
        int n;
        setup(0, 0, 0, 'h90, 'hA0, 3);
        setup(1, 0, 0, 'h98, 'hB0, 3);
        base = wcnt;
        wr(12'h000, 32'h3);
        n = 0;
        while (wcnt - base < 6 && n < 60) begin
            @(negedge clk);
            n++;
        end
        check(wcnt - base == 6, "R8 write count", wcnt - base, 6);
        for (int k = 0; k < 5; k++)
            check(wlog[base + k][7:4] != wlog[base + k + 1][7:4], "R8 alternation",
                  wlog[base + k + 1], ~wlog[base + k]);
        for (int i = 0; i < 3; i++) begin
            check(mem['hA0 + i] == pat('h90 + i), "R8 ch0 data", mem['hA0 + i], pat('h90 + i));
            check(mem['hB0 + i] == pat('h98 + i), "R8 ch1 data", mem['hB0 + i], pat('h98 + i));
        end
    endtask

    task automatic t_abort();
        logic [31:0] s1, s2;
        setup(3, 0, 0, 'h00, 'hC0, 20);
        wr(12'h000, 32'h8);
        repeat (5) @(negedge clk);
        wr(12'h000, 32'h8000_0008);
        check(evt_abort[3] && evt_done[3], "R7 abort events", {evt_abort[3], evt_done[3]}, 2'b11);
        repeat (2) @(negedge clk);
        rd(ra(3, 'h30), s1);
        check(s1 > 0 && s1 < 20, "R7 count partial", s1, 20);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (mem_req) check(0, "R7 port quiet", 1, 0);
        end
        rd(ra(3, 'h30), s2);
        check(s2 == s1, "R7 count frozen", s2, s1);
        wr(12'h000, 32'h8000_0004);
        check(evt_abort[2] && evt_done[2], "R7 idle abort", {evt_abort[2], evt_done[2]}, 2'b11);
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                if (!finished) begin
                    errors++;
                    checks++;
                    $display("FAIL watchdog actual=hung expected=finish");
                    $display("Result: errors=%0d of %0d checks", errors, checks);
                    $finish;
                end
            end
        join_none
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_copy_inc();
        t_dec_fixed();
        t_busy_ignore();
        t_zero();
        t_rr();
        t_abort();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule